// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a 16-bit word of sticky flags that tell software why the device last came out of reset or entered a low-power state. Single-cycle pulses from the reset and power-management logic set the flags: trap conflict, illegal condition, configuration mismatch, external pin reset, software reset instruction, watchdog timeout, sleep entry, idle entry, brown-out and power-on. A pulse marks a clear-watchdog instruction. Each flag has its own clearing rule. Power-on and brown-out wipe most of the history. The watchdog flag also drops on a power-save entry or a clear-watchdog instruction. The power-on and brown-out flags go away only when software writes them.

Software sees the word on a read bus at all times. A full-word write can set or clear any implemented flag. The block does not produce any reset itself. It only records the causes.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst_n` is low, `rd_data` reads 0x0000. Driving `rst_n` low clears the register without waiting for a clock edge.
- R2: Only bits 15, 14, 9, 7, 6, 4, 3, 2, 1 and 0 exist (mask 0xC2DF). Every other bit always reads 0 and ignores writes.
- R3: A power-on pulse sets bit 0 (power-on) and bit 1 (brown-out) at the next edge. In the same edge it clears bits 15, 14, 9, 7, 6, 4, 3 and 2.
- R4: A brown-out pulse sets bit 1 and clears bits 15, 14, 9, 7, 6, 4, 3 and 2. It leaves bit 0 unchanged.
- R5: Each of the following pulses sets its own flag at the next edge:
  - trap conflict sets bit 15
  - illegal condition sets bit 14
  - configuration mismatch sets bit 9
  - external pin reset sets bit 7
  - software reset sets bit 6
  - watchdog timeout sets bit 4
  - sleep entry sets bit 3
  - idle entry sets bit 2
- R6: A sleep pulse, an idle pulse or a clear-watchdog pulse clears the watchdog flag (bit 4).
- R7: No hardware event clears bit 0 or bit 1. Only a software write clears them.
- R8: When `wr_en` is high and no event pulse is present, the register takes `wr_data & 0xC2DF` at that edge.
- R9: If one flag gets a set event and a clear event in the same cycle, the flag ends up set.
- R10: A hardware set or clear overrides a software write to the same flag in the same cycle.
- R11: With no event and no write, the register holds its value.
- R12: Reset is released in step with the clock. The first two rising edges after `rst_n` goes high leave the register at zero, even if a write is presented. The third edge is the first one that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_trap_conflict | input | 1 | Trap conflict pulse |
| evt_illegal | input | 1 | Illegal opcode / uninitialised pointer / security pulse |
| evt_cfg_mismatch | input | 1 | Configuration shadow mismatch pulse |
| evt_ext_pin | input | 1 | External reset pin pulse |
| evt_sw_reset | input | 1 | Software reset instruction pulse |
| evt_wdt_timeout | input | 1 | Watchdog timeout pulse |
| evt_sleep | input | 1 | Sleep entry pulse |
| evt_idle | input | 1 | Idle entry pulse |
| evt_brownout | input | 1 | Brown-out reset pulse |
| evt_power_on | input | 1 | Power-on reset pulse |
| evt_wdt_clear | input | 1 | Clear-watchdog instruction pulse |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write data |
| rd_data | output | 16 | Current flag word |

## Verification
The hardest situations to reach are the ones where rules collide in a single cycle. Examples are a power-on pulse together with a trap pulse, a watchdog timeout together with sleep entry, and a software write that meets a hardware event. A routine sequence never lines these up. The stimulus table therefore schedules those pairs on purpose, after earlier rows have filled the register with a known mix of flags, so both the winner and the survivors are visible. Directed tests then cover the two edges after reset release, where a write is held but must not land, and an asynchronous reset taken while flags are set.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int REG_W  = 16;
  localparam int NUM_EV = 11;

  // flag positions (software decodes these)
  localparam int B_TRAP = 15;
  localparam int B_ILL  = 14;
  localparam int B_CM   = 9;
  localparam int B_EXT  = 7;
  localparam int B_SW   = 6;
  localparam int B_WDT  = 4;
  localparam int B_SLP  = 3;
  localparam int B_IDL  = 2;
  localparam int B_BOR  = 1;
  localparam int B_POR  = 0;

  // event vector indices
  localparam int EV_TRAP = 0;
  localparam int EV_ILL  = 1;
  localparam int EV_CM   = 2;
  localparam int EV_EXT  = 3;
  localparam int EV_SW   = 4;
  localparam int EV_WDT  = 5;
  localparam int EV_SLP  = 6;
  localparam int EV_IDL  = 7;
  localparam int EV_BOR  = 8;
  localparam int EV_POR  = 9;
  localparam int EV_WCLR = 10;

  typedef logic [NUM_EV-1:0] evt_vec_t;
  typedef logic [REG_W-1:0]  flag_word_t;

  function automatic evt_vec_t ev_bit(int idx);
    return evt_vec_t'(1) << idx;
  endfunction

  // events that force a flag to one
  function automatic evt_vec_t set_sources(int b);
    case (b)
      B_TRAP:  return ev_bit(EV_TRAP);
      B_ILL:   return ev_bit(EV_ILL);
      B_CM:    return ev_bit(EV_CM);
      B_EXT:   return ev_bit(EV_EXT);
      B_SW:    return ev_bit(EV_SW);
      B_WDT:   return ev_bit(EV_WDT);
      B_SLP:   return ev_bit(EV_SLP);
      B_IDL:   return ev_bit(EV_IDL);
      B_BOR:   return ev_bit(EV_BOR) | ev_bit(EV_POR);
      B_POR:   return ev_bit(EV_POR);
      default: return '0;
    endcase
  endfunction

  // events that force a flag to zero
  function automatic evt_vec_t clr_sources(int b);
    evt_vec_t cold;
    cold = ev_bit(EV_BOR) | ev_bit(EV_POR);
    case (b)
      B_TRAP, B_ILL, B_CM, B_EXT, B_SW, B_SLP, B_IDL: return cold;
      B_WDT:   return cold | ev_bit(EV_SLP) | ev_bit(EV_IDL) | ev_bit(EV_WCLR);
      default: return '0;
    endcase
  endfunction

  function automatic flag_word_t impl_mask();
    flag_word_t m;
    m = '0;
    for (int b = 0; b < REG_W; b++) m[b] = |set_sources(b);
    return m;
  endfunction

endpackage

// File: rtl/rst_cause_rst_sync.sv
module rst_cause_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rst_cause_evt_map.sv
module rst_cause_evt_map
  import rst_cause_pkg::*;
#(
  parameter int W = REG_W
) (
  input  evt_vec_t     ev,
  output logic [W-1:0] set_vec,
  output logic [W-1:0] clr_vec
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam evt_vec_t SET_SEL = set_sources(b);
    localparam evt_vec_t CLR_SEL = clr_sources(b);
    assign set_vec[b] = |(ev & SET_SEL);
    assign clr_vec[b] = |(ev & CLR_SEL);
  end
endmodule

// File: rtl/rst_cause_cell.sv
module rst_cause_cell #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic q_o
);
  logic q_d, q_en, q_r;

  always_comb begin
    q_d = q_r;
    if (wr_en_i) q_d = wr_bit_i;
    if (clr_i)   q_d = 1'b0;
    if (set_i)   q_d = 1'b1;
    if (!IMPL)   q_d = 1'b0;
    q_en = wr_en_i | clr_i | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= 1'b0;
    else if (q_en) q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_trap_conflict,
  input  logic         evt_illegal,
  input  logic         evt_cfg_mismatch,
  input  logic         evt_ext_pin,
  input  logic         evt_sw_reset,
  input  logic         evt_wdt_timeout,
  input  logic         evt_sleep,
  input  logic         evt_idle,
  input  logic         evt_brownout,
  input  logic         evt_power_on,
  input  logic         evt_wdt_clear,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  localparam flag_word_t IMPL = impl_mask();

  logic         rst_n_sync;
  evt_vec_t     ev_vec;
  logic [W-1:0] set_vec, clr_vec, flags;

  always_comb begin
    ev_vec          = '0;
    ev_vec[EV_TRAP] = evt_trap_conflict;
    ev_vec[EV_ILL]  = evt_illegal;
    ev_vec[EV_CM]   = evt_cfg_mismatch;
    ev_vec[EV_EXT]  = evt_ext_pin;
    ev_vec[EV_SW]   = evt_sw_reset;
    ev_vec[EV_WDT]  = evt_wdt_timeout;
    ev_vec[EV_SLP]  = evt_sleep;
    ev_vec[EV_IDL]  = evt_idle;
    ev_vec[EV_BOR]  = evt_brownout;
    ev_vec[EV_POR]  = evt_power_on;
    ev_vec[EV_WCLR] = evt_wdt_clear;
  end

  rst_cause_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  rst_cause_evt_map #(.W(W)) u_map (
    .ev(ev_vec), .set_vec(set_vec), .clr_vec(clr_vec)
  );

  for (genvar b = 0; b < W; b++) begin : g_flag
    rst_cause_cell #(.IMPL(IMPL[b])) u_cell (
      .clk(clk), .rst_n(rst_n_sync),
      .set_i(set_vec[b]), .clr_i(clr_vec[b]),
      .wr_en_i(wr_en), .wr_bit_i(wr_data[b]),
      .q_o(flags[b])
    );
  end

  assign rd_data = flags;
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk
  import rst_cause_pkg::*;
(
  input logic       clk,
  input logic       rst_n_sync,
  input evt_vec_t   ev,
  input logic       wr_en,
  input flag_word_t wr_data,
  input flag_word_t rd_data
);
  localparam flag_word_t MASK = impl_mask();

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_data & ~MASK) == '0);

  // R3
  por_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ev[EV_POR] |=> (rd_data[B_POR] && rd_data[B_BOR]));

  // R4
  bor_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ev[EV_BOR] |=> rd_data[B_BOR]);

  // R5
  trap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ev[EV_TRAP] |=> rd_data[B_TRAP]);

  // R6
  wdt_clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ev[EV_WCLR] && !ev[EV_WDT]) |=> !rd_data[B_WDT]);

  // R7
  por_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_data[B_POR] && !wr_en) |=> rd_data[B_POR]);

  // R8
  sw_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && ev == '0) |=> rd_data == ($past(wr_data) & MASK));

  // R9
  wdt_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ev[EV_WDT] && ev[EV_SLP]) |=> rd_data[B_WDT]);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!wr_en && ev == '0) |=> $stable(rd_data));
endmodule

bind rst_cause_reg rst_cause_chk u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .ev(ev_vec),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;

  // bench event encoding: one bit per event input
  localparam logic [10:0] E_NONE = 11'h000, E_TRAP = 11'h001, E_ILL = 11'h002,
    E_CM = 11'h004, E_EXT = 11'h008, E_SW = 11'h010, E_WDT = 11'h020,
    E_SLP = 11'h040, E_IDL = 11'h080, E_BOR = 11'h100, E_POR = 11'h200,
    E_WCLR = 11'h400;

  typedef struct packed {
    logic [10:0] ev;
    logic        we;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{E_POR,          1'b0, 16'h0000, 16'h0003, 8'd3},   // R3
    '{E_NONE,         1'b1, 16'h0000, 16'h0000, 8'd8},   // R8
    '{E_TRAP,         1'b0, 16'h0000, 16'h8000, 8'd5},   // R5
    '{E_ILL,          1'b0, 16'h0000, 16'hC000, 8'd5},
    '{E_CM,           1'b0, 16'h0000, 16'hC200, 8'd5},
    '{E_EXT,          1'b0, 16'h0000, 16'hC280, 8'd5},
    '{E_SW,           1'b0, 16'h0000, 16'hC2C0, 8'd5},
    '{E_WDT,          1'b0, 16'h0000, 16'hC2D0, 8'd5},
    '{E_IDL,          1'b0, 16'h0000, 16'hC2C4, 8'd6},   // R6
    '{E_SLP,          1'b0, 16'h0000, 16'hC2CC, 8'd5},
    '{E_NONE,         1'b0, 16'h0000, 16'hC2CC, 8'd11},  // R11
    '{E_BOR,          1'b0, 16'h0000, 16'h0002, 8'd4},   // R4
    '{E_NONE,         1'b1, 16'hFFFF, 16'hC2DF, 8'd2},   // R2
    '{E_BOR,          1'b0, 16'h0000, 16'h0003, 8'd7},   // R7
    '{E_POR | E_TRAP, 1'b0, 16'h0000, 16'h8003, 8'd9},   // R9
    '{E_WDT | E_SLP,  1'b0, 16'h0000, 16'h801B, 8'd9},
    '{E_WCLR,         1'b0, 16'h0000, 16'h800B, 8'd6},
    '{E_TRAP,         1'b1, 16'h0000, 16'h8000, 8'd10},  // R10
    '{E_BOR,          1'b1, 16'hFFFF, 16'h0003, 8'd10},
    '{E_NONE,         1'b1, 16'h0001, 16'h0001, 8'd7},
    '{E_WDT,          1'b0, 16'h0000, 16'h0011, 8'd5},
    '{E_NONE,         1'b1, 16'h1234, 16'h0214, 8'd2},
    '{E_SLP,          1'b0, 16'h0000, 16'h020C, 8'd6},
    '{E_IDL,          1'b0, 16'h0000, 16'h020C, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] ev;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg u_rst_cause_reg (
    .clk(clk), .rst_n(rst_n),
    .evt_trap_conflict(ev[0]), .evt_illegal(ev[1]), .evt_cfg_mismatch(ev[2]),
    .evt_ext_pin(ev[3]), .evt_sw_reset(ev[4]), .evt_wdt_timeout(ev[5]),
    .evt_sleep(ev[6]), .evt_idle(ev[7]), .evt_brownout(ev[8]),
    .evt_power_on(ev[9]), .evt_wdt_clear(ev[10]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input logic [15:0] exp, input string req);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev = E_NONE; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(16'h0000, "R1");
    // R12: write held across release; first two edges must not load it
    wr_en = 1'b1; wr_data = 16'hFFFF; rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(16'h0000, "R12");
    @(negedge clk);
    check(16'hC2DF, "R12");
    wr_data = 16'h0000;
    @(negedge clk);
    check(16'h0000, "R8");
    wr_en = 1'b0;
    for (int i = 0; i < NV; i++) begin
      ev = VEC[i].ev; wr_en = VEC[i].we; wr_data = VEC[i].wd;
      @(negedge clk);
      check(VEC[i].exp, $sformatf("R%0d row %0d", VEC[i].req, i));
    end
    ev = E_NONE; wr_en = 1'b0; wr_data = '0;
    // R1: asynchronous clear between edges
    #1 rst_n = 1'b0;
    #1 check(16'h0000, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(16'h0000, "R11");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule